// File: doc/BRIEF.md
# Ten-bit ECC symbol byte packer

This block moves eight 10-bit error-correction symbols between two shapes: a set of four 32-bit words that each carry two symbols, and a stream of ten bytes. In pack mode it takes the four words on a wide parallel input when a run starts and sends ten bytes out over a valid/ready byte port. In unpack mode it takes ten bytes over a valid/ready byte input and sends the eight symbols out over a valid/ready symbol port. Symbols leave highest index first, which is the order a syndrome loader further down the chain expects.

The byte layout puts the symbols end to end, least significant bit first, in an 80-bit stream. Symbol k takes stream bits 10k+9..10k, and byte j is stream bits 8j+7..8j. Each pass of two words therefore fills five bytes. One run handles one direction. The direction is taken from the mode input in the cycle the run starts. A start request made while a run is in progress is dropped.

Top module: `ecc10_byte_packer`

## Requirements
- R1: After reset, busy_o, out_valid_o, in_ready_o, sym_valid_o and done_o are all low.
- R2: A start_i pulse while busy_o is low starts a run, and busy_o is high in the next cycle. mode_i is sampled in that same cycle: 0 selects pack and 1 selects unpack. A start_i while busy_o is high has no effect on the run in progress or on its mode.
- R3: In pack mode, word w is words_i[32w+31:32w]. Its bits 9:0 are symbol 2w and its bits 25:16 are symbol 2w+1. Bits 15:10 and 31:26 are ignored.
- R4: Pack mode emits exactly ten bytes in order j = 0..9. For a pair of words a (even) and b (odd): byte 0 is a[7:0]; byte 1 is {a[21:16], a[9:8]}; byte 2 is {b[3:0], a[25:22]}; byte 3 is {b[17:16], b[9:4]}; byte 4 is b[25:18]. Words 0 and 1 give bytes 0-4, and words 2 and 3 give bytes 5-9.
- R5: Unpack mode accepts exactly ten bytes through in_valid_i/in_ready_o. The first byte is stream bits 7:0. Symbol k is stream bits 10k+9:10k.
- R6: Unpack mode emits the eight symbols in index order 7, 6, ..., 0, and sym_idx_o carries the index of the symbol on sym_o.
- R7: While an output is valid and its ready input is low, the output data, its index and its valid stay unchanged, and no byte or symbol is lost.
- R8: done_o is high exactly in the cycle of the final transfer of a run: the tenth byte in pack mode, or symbol 0 in unpack mode. busy_o is low in the following cycle.
- R9: in_ready_o is low during pack runs and while idle. out_valid_o is low during unpack runs. Bytes offered while idle are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run when idle |
| mode_i | input | 1 | 0 pack, 1 unpack, sampled at start |
| words_i | input | 128 | Four raw symbol words, sampled at pack start |
| out_byte_o | output | 8 | Packed byte |
| out_valid_o | output | 1 | Packed byte valid |
| out_ready_i | input | 1 | Packed byte accepted |
| in_byte_i | input | 8 | Byte to unpack |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted |
| sym_o | output | 10 | Unpacked symbol |
| sym_idx_o | output | 3 | Index of sym_o |
| sym_valid_o | output | 1 | Symbol valid |
| sym_ready_i | input | 1 | Symbol accepted |
| done_o | output | 1 | Final transfer of the run |
| busy_o | output | 1 | Run in progress |

## Verification
Pack is driven with all-zero words, all-ones words, and words that set only the masked bits. The all-ones case checks that the masked bits never reach the bytes, and the masked-only case must give ten zero bytes. A walking symbol pattern separates each bit field of the five-byte pass layout. Random words catch swapped passes or mixed-up symbol halves. Unpack is driven with random and all-ones byte streams, which show both the byte-to-stream order and the descending symbol order. Both directions run under random ready and valid gaps to exercise stalls. Start requests sent during a run, and bytes offered while idle, show that the sampled mode and the port gating hold.

// File: rtl/ecc10_pkg.sv
package ecc10_pkg;
  parameter int SYM_W  = 10;
  parameter int N_SYM  = 8;
  parameter int WORD_W = 32;
  parameter int HALF_W = 16;
  parameter int BYTE_W = 8;
  parameter int N_WORD = N_SYM / 2;
  parameter int STREAM_W = SYM_W * N_SYM;
  parameter int N_BYTE = STREAM_W / BYTE_W;

  typedef enum logic [1:0] {
    UP_IDLE = 2'd0,
    UP_FILL = 2'd1,
    UP_EMIT = 2'd2
  } unpack_state_e;
endpackage

// File: rtl/ecc10_word_unfold.sv
module ecc10_word_unfold
  import ecc10_pkg::*;
(
  input  logic [N_WORD*WORD_W-1:0] words_i,
  output logic [STREAM_W-1:0]      stream_o
);
  // symbol k lives in word k/2, low or high half
  for (genvar k = 0; k < N_SYM; k++) begin : g_sym
    localparam int WI = k / 2;
    localparam int LO = WI * WORD_W + (k % 2) * HALF_W;
    assign stream_o[k*SYM_W +: SYM_W] = words_i[LO +: SYM_W];
  end

  logic unused_bits;
  assign unused_bits = ^words_i;
endmodule

// File: rtl/ecc10_pack_seq.sv
module ecc10_pack_seq
  import ecc10_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [STREAM_W-1:0] stream_i,
  output logic [BYTE_W-1:0]   out_byte_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                done_o,
  output logic                busy_o
);
  localparam int CNT_W = $clog2(N_BYTE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BYTE - 1);

  logic [STREAM_W-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                act_q;
  logic                fire;

  assign fire        = act_q & out_ready_i;
  assign out_byte_o  = sh_q[BYTE_W-1:0];
  assign out_valid_o = act_q;
  assign busy_o      = act_q;
  assign done_o      = fire & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i && !act_q) begin
      sh_q  <= stream_i;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (fire) begin
      sh_q  <= sh_q >> BYTE_W;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) act_q <= 1'b0;
    end
  end

  assert_byte_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_byte_o));

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> cnt_q <= LAST);
endmodule

// File: rtl/ecc10_unpack_seq.sv
module ecc10_unpack_seq
  import ecc10_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [BYTE_W-1:0]        in_byte_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  output logic [SYM_W-1:0]         sym_o,
  output logic [$clog2(N_SYM)-1:0] sym_idx_o,
  output logic                     sym_valid_o,
  input  logic                     sym_ready_i,
  output logic                     done_o,
  output logic                     busy_o
);
  localparam int CNT_W = $clog2(N_BYTE);
  localparam int IDX_W = $clog2(N_SYM);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(N_BYTE - 1);
  localparam logic [IDX_W-1:0] TOP_S  = IDX_W'(N_SYM - 1);

  unpack_state_e       st_q;
  logic [STREAM_W-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [IDX_W-1:0]    idx_q;
  logic                take, give;

  assign in_ready_o  = (st_q == UP_FILL);
  assign sym_valid_o = (st_q == UP_EMIT);
  assign take        = in_ready_o & in_valid_i;
  assign give        = sym_valid_o & sym_ready_i;
  assign sym_o       = sh_q[STREAM_W-1 -: SYM_W];
  assign sym_idx_o   = idx_q;
  assign busy_o      = (st_q != UP_IDLE);
  assign done_o      = give & (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= UP_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        UP_IDLE: if (start_i) begin
          st_q  <= UP_FILL;
          cnt_q <= '0;
        end
        UP_FILL: if (take) begin
          // first byte drifts down to bits 7:0 after all bytes arrive
          sh_q  <= {in_byte_i, sh_q[STREAM_W-1:BYTE_W]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_B) begin
            st_q  <= UP_EMIT;
            idx_q <= TOP_S;
          end
        end
        UP_EMIT: if (give) begin
          sh_q  <= sh_q << SYM_W;
          idx_q <= idx_q - 1'b1;
          if (idx_q == '0) st_q <= UP_IDLE;
        end
        default: st_q <= UP_IDLE;
      endcase
    end
  end

  assert_sym_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && !sym_ready_i |=> sym_valid_o && $stable(sym_o) && $stable(sym_idx_o));

  assert_idx_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give && (idx_q != '0) |=> sym_valid_o && (sym_idx_o == $past(idx_q) - 1'b1));

  assert_fill_to_emit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (cnt_q == LAST_B) |=> sym_valid_o && !in_ready_o && (sym_idx_o == TOP_S));
endmodule

// File: rtl/ecc10_byte_packer.sv
module ecc10_byte_packer
  import ecc10_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     mode_i,
  input  logic [N_WORD*WORD_W-1:0] words_i,
  output logic [BYTE_W-1:0]        out_byte_o,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  input  logic [BYTE_W-1:0]        in_byte_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  output logic [SYM_W-1:0]         sym_o,
  output logic [$clog2(N_SYM)-1:0] sym_idx_o,
  output logic                     sym_valid_o,
  input  logic                     sym_ready_i,
  output logic                     done_o,
  output logic                     busy_o
);
  logic [STREAM_W-1:0] stream;
  logic start_ok, start_pk, start_up;
  logic pk_done, pk_busy, up_done, up_busy;

  assign start_ok = start_i & ~busy_o;
  assign start_pk = start_ok & ~mode_i;
  assign start_up = start_ok & mode_i;
  assign busy_o   = pk_busy | up_busy;
  assign done_o   = pk_done | up_done;

  ecc10_word_unfold u_unfold (
    .words_i  (words_i),
    .stream_o (stream)
  );

  ecc10_pack_seq u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_pk),
    .stream_i    (stream),
    .out_byte_o  (out_byte_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .done_o      (pk_done),
    .busy_o      (pk_busy)
  );

  ecc10_unpack_seq u_unpack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_up),
    .in_byte_i   (in_byte_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .sym_o       (sym_o),
    .sym_idx_o   (sym_idx_o),
    .sym_valid_o (sym_valid_o),
    .sym_ready_i (sym_ready_i),
    .done_o      (up_done),
    .busy_o      (up_busy)
  );

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_mode_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(pk_busy) || $fell(pk_busy) || $fell(up_busy));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_port_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_valid_o, in_ready_o, sym_valid_o}));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !in_ready_o && !out_valid_o && !sym_valid_o);
endmodule

// File: tb/sim_ecc10_byte_packer.sv
module sim_ecc10_byte_packer;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [127:0] words_i = '0;
  logic [7:0]   out_byte_o;
  logic         out_valid_o;
  logic         out_ready_i = 1'b0;
  logic [7:0]   in_byte_i = '0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [9:0]   sym_o;
  logic [2:0]   sym_idx_o;
  logic         sym_valid_o;
  logic         sym_ready_i = 1'b0;
  logic         done_o;
  logic         busy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  ecc10_byte_packer u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R4 per-pass byte layout
  function automatic logic [79:0] exp_bytes(input logic [127:0] w);
    logic [79:0] r = '0;
    for (int p = 0; p < 2; p++) begin
      logic [31:0] a, b;
      a = w[64*p +: 32];
      b = w[64*p+32 +: 32];
      r[40*p +: 8]    = a[7:0];
      r[40*p+8 +: 8]  = {a[21:16], a[9:8]};
      r[40*p+16 +: 8] = {b[3:0], a[25:22]};
      r[40*p+24 +: 8] = {b[17:16], b[9:4]};
      r[40*p+32 +: 8] = b[25:18];
    end
    return r;
  endfunction

  task automatic run_pack(input logic [127:0] w, input int stall, input bit poke);
    logic [79:0] e = exp_bytes(w);
    logic [7:0] held = '0;
    bit hold = 0;
    int j = 0;
    int guard = 0;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 1'b0; words_i = w;
    @(negedge clk_i);
    start_i = 1'b0; words_i = ~w;
    chk(busy_o == 1'b1, "R2 busy after start", {79'd0, busy_o}, 80'd1);
    while (j < 10 && guard < 2000) begin
      guard++;
      out_ready_i = (($urandom % 100) >= stall);
      if (poke && j == 3) begin start_i = 1'b1; mode_i = 1'b1; end
      else start_i = 1'b0;
      #1;
      chk(in_ready_o == 1'b0, "R9 in_ready in pack", {79'd0, in_ready_o}, 80'd0);
      if (hold) begin
        chk(out_valid_o && out_byte_o == held, "R7 byte held", {72'd0, out_byte_o}, {72'd0, held});
        hold = 0;
      end
      if (out_valid_o) begin
        if (out_ready_i) begin
          chk(out_byte_o == e[8*j +: 8], "R4 R3 byte value", {72'd0, out_byte_o}, {72'd0, e[8*j +: 8]});
          chk(done_o == (j == 9), "R8 done on last byte", {79'd0, done_o}, {79'd0, (j == 9)});
          j++;
        end else begin
          hold = 1; held = out_byte_o;
        end
      end
      @(negedge clk_i);
    end
    out_ready_i = 1'b0; start_i = 1'b0;
    chk(j == 10, "R4 byte count", 80'(j), 80'd10);
    #1;
    chk(busy_o == 1'b0 && out_valid_o == 1'b0, "R8 idle after done", {78'd0, busy_o, out_valid_o}, 80'd0);
  endtask

  task automatic run_unpack(input logic [79:0] bs, input int stall_in, input int stall_out, input bit poke);
    logic [9:0] hs = '0;
    logic [2:0] hi = '0;
    bit hold = 0;
    int j = 0;
    int k = 7;
    int guard = 0;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", {79'd0, busy_o}, 80'd1);
    while (j < 10 && guard < 2000) begin
      guard++;
      in_valid_i = (($urandom % 100) >= stall_in);
      in_byte_i  = in_valid_i ? bs[8*j +: 8] : 8'($urandom);
      if (poke && j == 4) begin start_i = 1'b1; mode_i = 1'b0; end
      else start_i = 1'b0;
      #1;
      chk(out_valid_o == 1'b0 && sym_valid_o == 1'b0, "R9 R5 no output in fill",
          {78'd0, out_valid_o, sym_valid_o}, 80'd0);
      if (in_valid_i && in_ready_o) j++;
      @(negedge clk_i);
    end
    in_valid_i = 1'b1; in_byte_i = 8'hA5; start_i = 1'b0;
    while (k >= 0 && guard < 4000) begin
      guard++;
      sym_ready_i = (($urandom % 100) >= stall_out);
      #1;
      chk(in_ready_o == 1'b0, "R5 no eleventh byte", {79'd0, in_ready_o}, 80'd0);
      if (hold) begin
        chk(sym_valid_o && sym_o == hs && sym_idx_o == hi, "R7 symbol held",
            {67'd0, sym_idx_o, sym_o}, {67'd0, hi, hs});
        hold = 0;
      end
      if (sym_valid_o) begin
        if (sym_ready_i) begin
          chk(sym_o == bs[10*k +: 10], "R5 symbol value", {70'd0, sym_o}, {70'd0, bs[10*k +: 10]});
          chk(sym_idx_o == 3'(k), "R6 symbol index", {77'd0, sym_idx_o}, 80'(k));
          chk(done_o == (k == 0), "R8 done on symbol 0", {79'd0, done_o}, {79'd0, (k == 0)});
          k--;
        end else begin
          hold = 1; hs = sym_o; hi = sym_idx_o;
        end
      end
      @(negedge clk_i);
    end
    sym_ready_i = 1'b0; in_valid_i = 1'b0;
    chk(k == -1, "R6 symbol count", 80'(k + 1), 80'd0);
    #1;
    chk(busy_o == 1'b0 && sym_valid_o == 1'b0, "R8 idle after done", {78'd0, busy_o, sym_valid_o}, 80'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    #1;
    chk({busy_o, out_valid_o, in_ready_o, sym_valid_o, done_o} == 5'b0, "R1 reset state",
        {75'd0, busy_o, out_valid_o, in_ready_o, sym_valid_o, done_o}, 80'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 bytes offered while idle are refused
    in_valid_i = 1'b1; in_byte_i = 8'h3C;
    #1;
    chk(in_ready_o == 1'b0 && busy_o == 1'b0, "R9 idle refuses bytes", {78'd0, in_ready_o, busy_o}, 80'd0);
    @(negedge clk_i);
    in_valid_i = 1'b0;

    run_pack(128'd0, 0, 0);
    run_pack({4{32'hFFFF_FFFF}}, 30, 0);
    run_pack({4{32'hFC00_FC00}}, 0, 0);                  // R3 masked bits only
    run_pack({32'h0080_0040, 32'h0020_0010, 32'h0008_0004, 32'h0002_0001}, 50, 1);
    run_pack({32'h0200_0100, 32'h0155_02AA, 32'h0001_0200, 32'h03FF_0000}, 0, 0);
    for (int i = 0; i < 20; i++)
      run_pack({$urandom, $urandom, $urandom, $urandom}, int'($urandom % 70), (i % 4) == 0);

    run_unpack({10{8'hFF}}, 0, 0, 0);
    run_unpack(80'h0123_4567_89AB_CDEF_F00D, 40, 40, 1);
    for (int i = 0; i < 20; i++)
      run_unpack({16'($urandom), $urandom, $urandom}, int'($urandom % 70), int'($urandom % 70), (i % 3) == 0);

    // mode switch back to pack after unpack
    run_pack({$urandom, $urandom, $urandom, $urandom}, 20, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule